// File: doc/BRIEF.md
# Multi-Sector Erase Collection Timer

This block gathers sector-erase requests for a flash array into one batch before the erase begins. A command decoder upstream sends single-cycle accept pulses: a sector-erase write carrying a sector index (taken from address bits 18 down to 16, so eight 64 KB sectors), any other command, an erase-suspend, and an erase-resume. The block records every requested sector in a mask and runs an acceptance window timer. Each new sector request restarts the window. When the window runs out with no new request, the block issues a one-cycle erase-start pulse and holds the mask for the erase engine.

While the window is open, a status flag (the bit 3 status flag of the read-back word) reads 0, which means more sectors are still accepted. Once the erase has begun, the flag reads 1. From then on, only suspend and resume have any effect. A done input from the erase engine clears the batch and returns the block to idle. The window length is a parameter counted in clock cycles; the nominal 80 µs window gives 4000 cycles at 50 MHz.

Top module: `erase_batch_collector`

## Requirements
- R1: After reset the sector mask is all zero, erase_start_o is 0, suspended_o is 0 and window_shut_o is 0.
- R2: A sector-erase pulse in idle or during the window sets mask bit `sec_index_i` (bit n = sector n). In idle it also opens the window. While the window is open, window_shut_o reads 0.
- R3: If no further sector-erase pulse arrives, erase_start_o is high for exactly one cycle, beginning WINDOW_CYCLES clock edges after the edge that sampled the last sector-erase pulse. window_shut_o becomes 1 in that same cycle.
- R4: Each sector-erase pulse inside the window restarts the count. Sectors may be added in any order and in any number, and repeating an index leaves the mask unchanged.
- R5: An other-command, suspend or resume pulse during the window clears the mask and returns to idle, and no erase start follows.
- R6: After the erase has begun, sector-erase and other-command pulses are ignored: the mask is unchanged and no new start pulse occurs.
- R7: A suspend pulse during the erase sets suspended_o. A resume pulse then clears it with the same mask. window_shut_o stays 1 throughout.
- R8: In idle, suspend, resume, other-command and done pulses have no effect: all outputs stay at their reset values.
- R9: erase_done_i during an active (unsuspended) erase clears the mask and window_shut_o and returns to idle. During a suspend it is ignored.
- R10: When pulses coincide, a cancel beats a sector-erase pulse during the window, and done beats suspend during the erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_erase_i | input | 1 | Sector-erase command accepted |
| sec_index_i | input | SEC_W (3) | Sector index from address bits 18:16 |
| other_cmd_i | input | 1 | Any other command accepted |
| suspend_i | input | 1 | Erase-suspend command accepted |
| resume_i | input | 1 | Erase-resume command accepted |
| erase_done_i | input | 1 | Erase engine finished |
| sector_mask_o | output | NUM_SECTORS (8) | Sectors queued for erase |
| erase_start_o | output | 1 | One-cycle erase start pulse |
| suspended_o | output | 1 | Erase is suspended |
| window_shut_o | output | 1 | Bit 3 status: 0 while collecting, 1 once erase has begun |

## Verification
A wrong internal state appears at the ports within one cycle. A state stuck in the window, or one that left it early, shows as a start pulse that is missing or early, or as a wrong window_shut_o on the very next cycle. A timer that fails to restart moves the start pulse earlier by the gap between requests. A mask that keeps stale bits after a cancel or a done shows directly on sector_mask_o at the next edge. Because every output is registered, comparing against a cycle-exact model on every clock pins each fault to the edge where it arose.

// File: rtl/erase_batch_pkg.sv
package erase_batch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_ERASE   = 2'd2,
    ST_SUSP    = 2'd3
  } ebc_state_t;

  // One-hot sector select, wide enough for up to 32 sectors.
  function automatic logic [31:0] sector_bit(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

  // True on the last cycle of the window, counting from zero.
  function automatic logic window_hit(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // True when the erase engine owns the mask.
  function automatic logic erase_owned(input ebc_state_t st);
    return (st == ST_ERASE) || (st == ST_SUSP);
  endfunction

endpackage

// File: rtl/ebc_window_timer.sv
module ebc_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 4000,
  localparam int CW = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  import erase_batch_pkg::*;

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !restart_i && window_hit(int'(cnt_q), WINDOW_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expire_o)  cnt_q <= cnt_q + 1'b1;
    else                 cnt_q <= '0;
  end

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < WINDOW_CYCLES) else $error("timer past window"); // R3

  AST_TIMER_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0) else $error("timer not restarted"); // R4

endmodule

// File: rtl/ebc_mask_reg.sv
module ebc_mask_reg #(
  parameter int unsigned NUM_SECTORS = 8,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_i,
  input  logic                   clear_i,
  input  logic [SEC_W-1:0]       index_i,
  output logic [NUM_SECTORS-1:0] mask_o
);
  import erase_batch_pkg::*;

  logic [NUM_SECTORS-1:0] mask_q;
  logic [NUM_SECTORS-1:0] sel;

  assign sel = NUM_SECTORS'(sector_bit(int'(index_i)));

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (clear_i) mask_q <= '0;
    else if (set_i)   mask_q <= mask_q | sel;
  end

  assign mask_o = mask_q;

  AST_MASK_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i) |=> ((mask_q & $past(mask_q)) == $past(mask_q))) else $error("mask bit lost"); // R4

  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> mask_q == '0) else $error("mask not cleared"); // R5

endmodule

// File: rtl/ebc_ctrl_fsm.sv
module ebc_ctrl_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_erase_i,
  input  logic other_cmd_i,
  input  logic suspend_i,
  input  logic resume_i,
  input  logic erase_done_i,
  input  logic expire_i,
  output erase_batch_pkg::ebc_state_t state_o,
  output logic set_o,
  output logic clear_o,
  output logic restart_o,
  output logic run_o,
  output logic start_o
);
  import erase_batch_pkg::*;

  ebc_state_t st_q, st_d;
  logic       start_q;
  logic       cancel;

  // Any accepted pulse other than a sector request breaks the window.
  assign cancel = other_cmd_i || suspend_i || resume_i;

  always_comb begin
    st_d      = st_q;
    set_o     = 1'b0;
    clear_o   = 1'b0;
    restart_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sec_erase_i) begin
          st_d      = ST_COLLECT;
          set_o     = 1'b1;
          restart_o = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (cancel) begin
          st_d    = ST_IDLE;
          clear_o = 1'b1;
        end else if (sec_erase_i) begin
          set_o     = 1'b1;
          restart_o = 1'b1;
        end else if (expire_i) begin
          st_d = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (erase_done_i) begin
          st_d    = ST_IDLE;
          clear_o = 1'b1;
        end else if (suspend_i) begin
          st_d = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (resume_i) st_d = ST_ERASE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign run_o = (st_q == ST_COLLECT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= (st_q == ST_COLLECT) && (st_d == ST_ERASE);
    end
  end

  assign state_o = st_q;
  assign start_o = start_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q) else $error("start longer than one cycle"); // R3

  AST_START_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(st_q) == ST_COLLECT) else $error("start outside window"); // R3

  AST_SUSP_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && $past(st_q) != ST_SUSP) |-> $past(st_q) == ST_ERASE) else $error("bad suspend entry"); // R7

  AST_SUSP_HOLDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && !resume_i) |=> st_q == ST_SUSP) else $error("suspend left"); // R9

endmodule

// File: rtl/erase_batch_collector.sv
module erase_batch_collector #(
  parameter int unsigned NUM_SECTORS   = 8,
  parameter int unsigned WINDOW_CYCLES = 4000,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_erase_i,
  input  logic [SEC_W-1:0]       sec_index_i,
  input  logic                   other_cmd_i,
  input  logic                   suspend_i,
  input  logic                   resume_i,
  input  logic                   erase_done_i,
  output logic [NUM_SECTORS-1:0] sector_mask_o,
  output logic                   erase_start_o,
  output logic                   suspended_o,
  output logic                   window_shut_o
);
  import erase_batch_pkg::*;

  ebc_state_t state;
  logic       mask_set;
  logic       mask_clear;
  logic       tmr_restart;
  logic       tmr_run;
  logic       tmr_expire;

  ebc_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_erase_i  (sec_erase_i),
    .other_cmd_i  (other_cmd_i),
    .suspend_i    (suspend_i),
    .resume_i     (resume_i),
    .erase_done_i (erase_done_i),
    .expire_i     (tmr_expire),
    .state_o      (state),
    .set_o        (mask_set),
    .clear_o      (mask_clear),
    .restart_o    (tmr_restart),
    .run_o        (tmr_run),
    .start_o      (erase_start_o)
  );

  ebc_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (tmr_run),
    .restart_i (tmr_restart),
    .expire_o  (tmr_expire)
  );

  ebc_mask_reg #(.NUM_SECTORS(NUM_SECTORS)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (mask_set),
    .clear_i (mask_clear),
    .index_i (sec_index_i),
    .mask_o  (sector_mask_o)
  );

  assign suspended_o   = (state == ST_SUSP);
  assign window_shut_o = erase_owned(state);

  AST_IDLE_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> sector_mask_o == '0) else $error("idle with mask"); // R9

  AST_BUSY_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> sector_mask_o != '0) else $error("busy without mask"); // R2

  AST_ERASE_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (window_shut_o && !erase_done_i) |=> $stable(sector_mask_o)) else $error("mask moved in erase"); // R6

  AST_START_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |-> window_shut_o && !suspended_o) else $error("flag not set at start"); // R3

endmodule

// File: tb/erase_batch_collector_tb_top.sv
module erase_batch_collector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int W  = 12;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec = 1'b0;
  logic [2:0] idx = '0;
  logic oth = 1'b0, sus = 1'b0, res = 1'b0, dn = 1'b0;
  logic [NS-1:0] mask;
  logic start, susp_f, shut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int  m_st = 0;      // 0 idle, 1 window, 2 erasing, 3 suspended
  int  m_mask = 0;
  int  m_rem = 0;
  bit  m_start = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_batch_collector #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_erase_i(sec), .sec_index_i(idx),
    .other_cmd_i(oth), .suspend_i(sus), .resume_i(res), .erase_done_i(dn),
    .sector_mask_o(mask), .erase_start_o(start), .suspended_o(susp_f),
    .window_shut_o(shut));

  always @(posedge clk) begin
    m_start = 0;
    if (!rst_n) begin
      m_st = 0; m_mask = 0; m_rem = 0;
    end else begin
      if (m_st == 0) begin
        if (sec) begin m_st = 1; m_mask = m_mask | (1 << idx); m_rem = W; end
      end else if (m_st == 1) begin
        if (oth || sus || res) begin m_st = 0; m_mask = 0; end
        else if (sec) begin m_mask = m_mask | (1 << idx); m_rem = W; end
        else begin
          m_rem = m_rem - 1;
          if (m_rem == 0) begin m_st = 2; m_start = 1; end
        end
      end else if (m_st == 2) begin
        if (dn) begin m_st = 0; m_mask = 0; end
        else if (sus) m_st = 3;
      end else begin
        if (res) m_st = 2;
      end
    end
  end

  task automatic compare();
    logic [NS-1:0] em;
    logic es, eu, ew;
    em = NS'(m_mask);
    es = m_start;
    eu = (m_st == 3);
    ew = (m_st >= 2);
    checks++;
    if (mask !== em || start !== es || susp_f !== eu || shut !== ew) begin
      fails++;
      $display("FAIL %s: mask=%b start=%b susp=%b shut=%b expected mask=%b start=%b susp=%b shut=%b",
               tag, mask, start, susp_f, shut, em, es, eu, ew);
    end
  endtask

  always @(negedge clk) if (rst_n) compare();

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic drive(input bit s, input int i, input bit o, input bit su, input bit r, input bit d);
    @(negedge clk);
    #1;
    sec = s; idx = 3'(i); oth = o; sus = su; res = r; dn = d;
    @(negedge clk);
    #1;
    sec = 0; oth = 0; sus = 0; res = 0; dn = 0;
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    checks++;
    if (mask !== '0 || start !== 1'b0 || susp_f !== 1'b0 || shut !== 1'b0) begin
      fails++;
      $display("FAIL R1: mask=%b start=%b susp=%b shut=%b expected all zero", mask, start, susp_f, shut);
    end
    rst_n = 1'b1;
    wait_cycles(2);

    tag = "R2/R3 single sector";
    drive(1, 3, 0, 0, 0, 0);
    wait_cycles(W + 4);
    tag = "R9 done in erase";
    drive(0, 0, 0, 0, 0, 1);
    wait_cycles(3);

    tag = "R4 restart and order";
    drive(1, 0, 0, 0, 0, 0);
    wait_cycles(5);
    drive(1, 7, 0, 0, 0, 0);
    wait_cycles(W - 3);
    drive(1, 7, 0, 0, 0, 0);
    drive(1, 2, 0, 0, 0, 0);
    wait_cycles(W + 3);
    tag = "R6 ignored during erase";
    drive(1, 5, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    wait_cycles(W + 2);
    tag = "R9 done clears";
    drive(0, 0, 0, 0, 0, 1);
    wait_cycles(2);

    tag = "R5 cancel by other";
    drive(1, 1, 0, 0, 0, 0);
    wait_cycles(4);
    drive(0, 0, 1, 0, 0, 0);
    wait_cycles(W + 2);
    tag = "R5 cancel by suspend";
    drive(1, 4, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    wait_cycles(W + 2);
    tag = "R5 cancel by resume";
    drive(1, 6, 0, 0, 0, 0);
    wait_cycles(W - 2);
    drive(0, 0, 0, 0, 1, 0);
    wait_cycles(W + 2);

    tag = "R8 idle ignores";
    drive(0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    drive(0, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    wait_cycles(2);

    tag = "R7 suspend and resume";
    drive(1, 2, 0, 0, 0, 0);
    wait_cycles(W + 2);
    drive(0, 0, 0, 1, 0, 0);
    wait_cycles(3);
    drive(1, 3, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    tag = "R9 done ignored in suspend";
    drive(0, 0, 0, 0, 0, 1);
    wait_cycles(2);
    tag = "R7 resume";
    drive(0, 0, 0, 0, 1, 0);
    wait_cycles(3);
    drive(0, 0, 0, 0, 0, 1);
    wait_cycles(2);

    tag = "R10 cancel beats sector";
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 5, 1, 0, 0, 0);
    wait_cycles(W + 2);
    tag = "R10 done beats suspend";
    drive(1, 0, 0, 0, 0, 0);
    wait_cycles(W + 1);
    drive(0, 0, 0, 1, 0, 1);
    wait_cycles(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule